// File: doc/BRIEF.md
# Multibank Ping-Pong Buffer Crossbar

This block is a shared on-chip staging buffer. Several accelerator prefetch ports sit on one side and a single bus port leads toward external memory on the other. Storage is split into physical banks, and each bank has two halves that can be used at the same time. Each bank carries one role bit that says which half belongs to the accelerator side. The bus side is meant to refill or drain the other half. A swap command flips that bit, so a freshly filled half passes to the accelerator without any copy.

Each accelerator port can reach any bank through a crossbar. A control interface writes a bank-to-port ownership map, and only the owning port may touch a bank. The accelerator port always uses the half that its role bit selects. The bus port names its half explicitly. If the bus hits the half that the owning port is using in the same cycle, the bus is held off through its ready signal. Reads on either side return their data one cycle after the request, together with a valid strobe. Words are 64 bits wide.

Top module: `pingpong_xbar`

## Requirements
- R1: After reset no bank has an owner, every role bit selects half 0 for the accelerator side, all error flags and valid strobes are low, and bus_ready is high while no bus request is made.
- R2: A port read of a bank that port owns returns the stored word with acc_rvalid high exactly one cycle after the request. A port write produces no acc_rvalid.
- R3: A port request to a bank that is unowned or owned by another port changes no storage and returns no acc_rvalid. It sets that port's acc_err bit, which stays set until reset.
- R4: An accepted bus read (bus_req and bus_ready both high, bus_we low) returns the word at bus_bank, bus_half (0 or 1) and bus_addr, with bus_rvalid high one cycle later. An accepted bus write stores the word.
- R5: In the same cycle, an owner access to a bank and a bus access to the other half of that bank are both performed, and bus_ready stays high.
- R6: If the bus targets the accelerator-side half of a bank while that bank's owner accesses it in the same cycle, bus_ready is low, the owner access is performed and the bus access is not. A stalled bus read gives no bus_rvalid.
- R7: A swap request for a bank with no accepted access in that cycle raises swap_ack and flips the bank's role bit. After that, the owner sees the half that the bus side held before.
- R8: A swap request for a bank that has an owner access or an accepted bus access in the same cycle gets swap_ack low, and the role bit does not change.
- R9: Different ports that access different banks they own in the same cycle are all served independently.
- R10: Writing the ownership map for a bank moves it to the new port at once. Requests from the previous owner are then treated as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one ownership map entry |
| cfg_bank | input | BW | Bank whose entry is written |
| cfg_owner_vld | input | 1 | Entry valid (bank owned) |
| cfg_owner | input | PW | Owning port index |
| swap_req | input | 1 | Request to flip a bank's role bit |
| swap_bank | input | BW | Bank to swap |
| swap_ack | output | 1 | Swap is taken at this edge |
| acc_req | input | NP | Per-port request |
| acc_we | input | NP | Per-port write enable |
| acc_bank | input | NP x BW | Per-port bank select |
| acc_addr | input | NP x AW | Per-port word address in the half |
| acc_wdata | input | NP x 64 | Per-port write data |
| acc_rvalid | output | NP | Per-port read data valid |
| acc_rdata | output | NP x 64 | Per-port read data |
| acc_err | output | NP | Per-port sticky ownership error |
| bus_req | input | 1 | Bus port request |
| bus_we | input | 1 | Bus port write enable |
| bus_half | input | 1 | Half addressed by the bus port |
| bus_bank | input | BW | Bank addressed by the bus port |
| bus_addr | input | AW | Word address in the half |
| bus_wdata | input | 64 | Bus write data |
| bus_ready | output | 1 | Bus request is accepted this cycle |
| bus_rvalid | output | 1 | Bus read data valid |
| bus_rdata | output | 64 | Bus read data |

## Verification
The hardest situations to reach are the same-cycle collisions. One is the owning port and the bus landing on one half of a bank. The other is a swap request arriving while that bank is being accessed. In normal traffic these happen only by timing accident. The stimulus forces them by applying the owner request, the bus request and the swap request within one drive window. It samples the combinational bus_ready and swap_ack before the edge. Later reads through both sides then show which half each side actually reached and whether the stalled write was dropped.

// File: rtl/pp_xbar_pkg.sv
// Shared definitions for the ping-pong buffer crossbar.
// Assumes a fixed 64-bit word; index widths are derived with idx_w.
package pp_xbar_pkg;
    localparam int unsigned WORD_W = 64;
    typedef logic [WORD_W-1:0] word_t;

    // Width of an index over n items, never zero.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pp_bank.sv
// One physical bank holding two independently addressed halves.
// Port A is the accelerator side, port B the bus side. Assumes the
// crossbar never enables both ports on the same half in one cycle.
// Read data is registered: valid one cycle after the request.
module pp_bank
    import pp_xbar_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = idx_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic          a_half,
    input  logic [AW-1:0] a_addr,
    input  word_t         a_wdata,
    output word_t         a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic          b_half,
    input  logic [AW-1:0] b_addr,
    input  word_t         b_wdata,
    output word_t         b_rdata
);
    word_t mem [2][DEPTH];

    // Store writes from either side into its selected half.
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_half][a_addr] <= a_wdata;
        if (b_en && b_we) mem[b_half][b_addr] <= b_wdata;
    end

    // Capture read data for each side one cycle after its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_en && !a_we) a_rdata <= mem[a_half][a_addr];
            if (b_en && !b_we) b_rdata <= mem[b_half][b_addr];
        end
    end
endmodule

// File: rtl/pp_owner_map.sv
// Ownership table and per-bank role bits.
// owner_vld/owner_id give the single port allowed on each bank.
// acc_half gives the half the accelerator side uses; the swap flips it
// only when bank_busy reports no accepted access to that bank this cycle.
module pp_owner_map
    import pp_xbar_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_PORTS = 4,
    localparam int unsigned BW = idx_w(NUM_BANKS),
    localparam int unsigned PW = idx_w(NUM_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [BW-1:0]                 cfg_bank,
    input  logic                          cfg_owner_vld,
    input  logic [PW-1:0]                 cfg_owner,
    input  logic                          swap_req,
    input  logic [BW-1:0]                 swap_bank,
    input  logic [NUM_BANKS-1:0]          bank_busy,
    output logic                          swap_ack,
    output logic [NUM_BANKS-1:0]          owner_vld,
    output logic [NUM_BANKS-1:0][PW-1:0]  owner_id,
    output logic [NUM_BANKS-1:0]          acc_half
);
    // Accept a swap only on a quiet bank.
    assign swap_ack = swap_req && !bank_busy[swap_bank];

    // Hold ownership entries and role bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_vld <= '0;
            owner_id  <= '0;
            acc_half  <= '0;
        end else begin
            if (cfg_we) begin
                owner_vld[cfg_bank] <= cfg_owner_vld;
                owner_id[cfg_bank]  <= cfg_owner;
            end
            if (swap_ack) acc_half[swap_bank] <= ~acc_half[swap_bank];
        end
    end
endmodule

// File: rtl/pp_xbar_route.sv
// Combinational crossbar: routes each bank's owning port onto its
// accelerator side, checks legality per port, and resolves clashes
// between the owner and the bus in favour of the owner.
module pp_xbar_route
    import pp_xbar_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DEPTH     = 16,
    localparam int unsigned BW = idx_w(NUM_BANKS),
    localparam int unsigned PW = idx_w(NUM_PORTS),
    localparam int unsigned AW = idx_w(DEPTH)
) (
    input  logic [NUM_PORTS-1:0]          acc_req,
    input  logic [NUM_PORTS-1:0]          acc_we,
    input  logic [NUM_PORTS-1:0][BW-1:0]  acc_bank,
    input  logic [NUM_PORTS-1:0][AW-1:0]  acc_addr,
    input  word_t [NUM_PORTS-1:0]         acc_wdata,
    input  logic [NUM_BANKS-1:0]          owner_vld,
    input  logic [NUM_BANKS-1:0][PW-1:0]  owner_id,
    input  logic [NUM_BANKS-1:0]          acc_half,
    input  logic                          bus_req,
    input  logic                          bus_half,
    input  logic [BW-1:0]                 bus_bank,
    output logic [NUM_PORTS-1:0]          legal,
    output logic [NUM_BANKS-1:0]          a_en,
    output logic [NUM_BANKS-1:0]          a_we,
    output logic [NUM_BANKS-1:0][AW-1:0]  a_addr,
    output word_t [NUM_BANKS-1:0]         a_wdata,
    output logic [NUM_BANKS-1:0]          b_en,
    output logic [NUM_BANKS-1:0]          bank_busy,
    output logic                          bus_ready
);
    // Bus loses when it lands on the half the owner is using this cycle.
    assign bus_ready = !(bus_req && a_en[bus_bank] &&
                         (bus_half == acc_half[bus_bank]));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [PW-1:0] own;
        assign own = owner_id[b];
        // Select the owning port's request for this bank.
        assign a_en[b]    = owner_vld[b] && acc_req[own] &&
                            (acc_bank[own] == BW'(b));
        assign a_we[b]    = acc_we[own];
        assign a_addr[b]  = acc_addr[own];
        assign a_wdata[b] = acc_wdata[own];
        // Enable the bus side only for an accepted request.
        assign b_en[b]      = bus_req && bus_ready && (bus_bank == BW'(b));
        assign bank_busy[b] = a_en[b] || b_en[b];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // A request is legal only on a bank this port owns.
        assign legal[p] = acc_req[p] && owner_vld[acc_bank[p]] &&
                          (owner_id[acc_bank[p]] == PW'(p));
    end
endmodule

// File: rtl/pingpong_xbar.sv
// Multibank ping-pong buffer with an accelerator crossbar and one bus port.
// Assumes a single owner per bank set through cfg_*; the accelerator side
// always uses the half picked by the bank's role bit, the bus names its half.
// Read data on both sides returns one cycle after the request.
module pingpong_xbar
    import pp_xbar_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DEPTH     = 16,
    localparam int unsigned BW = idx_w(NUM_BANKS),
    localparam int unsigned PW = idx_w(NUM_PORTS),
    localparam int unsigned AW = idx_w(DEPTH)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [BW-1:0]                      cfg_bank,
    input  logic                               cfg_owner_vld,
    input  logic [PW-1:0]                      cfg_owner,
    input  logic                               swap_req,
    input  logic [BW-1:0]                      swap_bank,
    output logic                               swap_ack,
    input  logic [NUM_PORTS-1:0]               acc_req,
    input  logic [NUM_PORTS-1:0]               acc_we,
    input  logic [NUM_PORTS-1:0][BW-1:0]       acc_bank,
    input  logic [NUM_PORTS-1:0][AW-1:0]       acc_addr,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]   acc_wdata,
    output logic [NUM_PORTS-1:0]               acc_rvalid,
    output logic [NUM_PORTS-1:0][WORD_W-1:0]   acc_rdata,
    output logic [NUM_PORTS-1:0]               acc_err,
    input  logic                               bus_req,
    input  logic                               bus_we,
    input  logic                               bus_half,
    input  logic [BW-1:0]                      bus_bank,
    input  logic [AW-1:0]                      bus_addr,
    input  logic [WORD_W-1:0]                  bus_wdata,
    output logic                               bus_ready,
    output logic                               bus_rvalid,
    output logic [WORD_W-1:0]                  bus_rdata
);
    logic [NUM_BANKS-1:0]          owner_vld, acc_half, bank_busy;
    logic [NUM_BANKS-1:0][PW-1:0]  owner_id;
    logic [NUM_BANKS-1:0]          a_en, a_we, b_en;
    logic [NUM_BANKS-1:0][AW-1:0]  a_addr;
    word_t [NUM_BANKS-1:0]         a_wdata, a_rd, b_rd;
    logic [NUM_PORTS-1:0]          legal;
    logic [NUM_PORTS-1:0][BW-1:0]  rbank_q;
    logic [BW-1:0]                 bus_rbank_q;

    pp_owner_map #(.NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS)) u_map (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_owner_vld(cfg_owner_vld), .cfg_owner(cfg_owner),
        .swap_req(swap_req), .swap_bank(swap_bank),
        .bank_busy(bank_busy), .swap_ack(swap_ack),
        .owner_vld(owner_vld), .owner_id(owner_id), .acc_half(acc_half)
    );

    pp_xbar_route #(.NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS),
                    .DEPTH(DEPTH)) u_route (
        .acc_req(acc_req), .acc_we(acc_we), .acc_bank(acc_bank),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .owner_vld(owner_vld), .owner_id(owner_id), .acc_half(acc_half),
        .bus_req(bus_req), .bus_half(bus_half), .bus_bank(bus_bank),
        .legal(legal), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .a_wdata(a_wdata), .b_en(b_en), .bank_busy(bank_busy),
        .bus_ready(bus_ready)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pp_bank #(.DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .a_en(a_en[b]), .a_we(a_we[b]), .a_half(acc_half[b]),
            .a_addr(a_addr[b]), .a_wdata(a_wdata[b]), .a_rdata(a_rd[b]),
            .b_en(b_en[b]), .b_we(bus_we), .b_half(bus_half),
            .b_addr(bus_addr), .b_wdata(bus_wdata), .b_rdata(b_rd[b])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ret
        // Return the registered word of the bank this port last read.
        assign acc_rdata[p] = a_rd[rbank_q[p]];
    end
    assign bus_rdata = b_rd[bus_rbank_q];

    // Track read strobes, return bank tags and sticky ownership errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid  <= '0;
            acc_err     <= '0;
            rbank_q     <= '0;
            bus_rvalid  <= 1'b0;
            bus_rbank_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                acc_rvalid[p] <= legal[p] && !acc_we[p];
                acc_err[p]    <= acc_err[p] || (acc_req[p] && !legal[p]);
                if (legal[p]) rbank_q[p] <= acc_bank[p];
            end
            bus_rvalid <= bus_req && bus_ready && !bus_we;
            if (bus_req && bus_ready) bus_rbank_q <= bus_bank;
        end
    end
endmodule

// File: rtl/pp_xbar_chk.sv
// Port-level temporal checks for pingpong_xbar, attached by bind.
module pp_xbar_chk
    import pp_xbar_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DEPTH     = 16,
    localparam int unsigned BW = idx_w(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 swap_req,
    input logic [BW-1:0]        swap_bank,
    input logic                 swap_ack,
    input logic [NUM_PORTS-1:0] acc_req,
    input logic [NUM_PORTS-1:0] acc_we,
    input logic [NUM_PORTS-1:0] acc_rvalid,
    input logic [NUM_PORTS-1:0] acc_err,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [BW-1:0]        bus_bank,
    input logic                 bus_ready,
    input logic                 bus_rvalid
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        a_r2_rvalid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
            acc_rvalid[p] |-> $past(acc_req[p] && !acc_we[p]));
        a_r2_no_rvalid_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            $past(acc_req[p] && acc_we[p]) |-> !acc_rvalid[p]);
        a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            acc_err[p] |=> acc_err[p]);
    end

    a_r4_bus_rvalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && bus_ready && !bus_we));
    a_r6_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> bus_req);
    a_r6_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_req && !bus_ready) |-> !bus_rvalid);
    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> swap_req);
    a_r8_ack_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> !(bus_req && bus_ready && bus_bank == swap_bank));
endmodule

bind pingpong_xbar pp_xbar_chk #(
    .NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/tb_pingpong_xbar.sv
module tb_pingpong_xbar;
    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic             cfg_we, cfg_owner_vld, swap_req, swap_ack;
    logic [1:0]       cfg_bank, cfg_owner, swap_bank;
    logic [3:0]       acc_req, acc_we, acc_rvalid, acc_err;
    logic [3:0][1:0]  acc_bank;
    logic [3:0][3:0]  acc_addr;
    logic [3:0][63:0] acc_wdata, acc_rdata;
    logic             bus_req, bus_we, bus_half, bus_ready, bus_rvalid;
    logic [1:0]       bus_bank;
    logic [3:0]       bus_addr;
    logic [63:0]      bus_wdata, bus_rdata;

    pingpong_xbar dut (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [63:0] D_A = 64'hA5A5_0000_1111_0003;
    localparam logic [63:0] D_B = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D_C = 64'hCAFE_F00D_0000_0001;
    localparam logic [63:0] D_D = 64'hFFFF_0000_FFFF_0000;
    localparam logic [63:0] D_E = 64'h5A5A_EEEE_0000_0042;
    localparam logic [63:0] D_F = 64'h1111_2222_3333_4444;
    localparam logic [63:0] D_Z = 64'hDEAD_DEAD_DEAD_DEAD;

    typedef struct packed {
        logic        we;
        logic [1:0]  port;
        logic [1:0]  bank;
        logic [3:0]  addr;
        logic [63:0] wd;
        logic        ev;
        logic [63:0] ed;
    } vec_t;

    // Owners: bank0->p0, bank1->p1, bank2->p2, bank3 unowned.
    localparam vec_t VECS [11] = '{
        '{1'b1, 2'd0, 2'd0, 4'd3,  D_A,   1'b0, 64'd0},
        '{1'b1, 2'd0, 2'd0, 4'd7,  D_B,   1'b0, 64'd0},
        '{1'b0, 2'd0, 2'd0, 4'd3,  64'd0, 1'b1, D_A},
        '{1'b0, 2'd0, 2'd0, 4'd7,  64'd0, 1'b1, D_B},
        '{1'b1, 2'd1, 2'd1, 4'd0,  D_C,   1'b0, 64'd0},
        '{1'b0, 2'd1, 2'd1, 4'd0,  64'd0, 1'b1, D_C},
        '{1'b1, 2'd1, 2'd0, 4'd3,  D_Z,   1'b0, 64'd0},
        '{1'b0, 2'd0, 2'd0, 4'd3,  64'd0, 1'b1, D_A},
        '{1'b0, 2'd0, 2'd3, 4'd0,  64'd0, 1'b0, 64'd0},
        '{1'b1, 2'd0, 2'd0, 4'd15, D_D,   1'b0, 64'd0},
        '{1'b0, 2'd0, 2'd0, 4'd15, 64'd0, 1'b1, D_D}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; cfg_bank = 0; cfg_owner_vld = 0; cfg_owner = 0;
        swap_req = 0; swap_bank = 0;
        acc_req = 0; acc_we = 0; acc_bank = '0; acc_addr = '0; acc_wdata = '0;
        bus_req = 0; bus_we = 0; bus_half = 0; bus_bank = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc(input int p, input logic we, input logic [1:0] b,
                       input logic [3:0] a, input logic [63:0] d);
        acc_req[p] = 1'b1; acc_we[p] = we; acc_bank[p] = b;
        acc_addr[p] = a; acc_wdata[p] = d;
    endtask

    task automatic bus(input logic we, input logic h, input logic [1:0] b,
                       input logic [3:0] a, input logic [63:0] d);
        bus_req = 1'b1; bus_we = we; bus_half = h; bus_bank = b;
        bus_addr = a; bus_wdata = d;
    endtask

    task automatic own(input logic [1:0] b, input logic v, input logic [1:0] p);
        idle(); cfg_we = 1; cfg_bank = b; cfg_owner_vld = v; cfg_owner = p;
        tick(); idle();
    endtask

    task automatic do_reset();
        idle(); rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        chk("R1 acc_rvalid", 64'(acc_rvalid), 64'd0);
        chk("R1 acc_err", 64'(acc_err), 64'd0);
        chk("R1 bus_ready idle", 64'(bus_ready), 64'd1);
        chk("R1 bus_rvalid", 64'(bus_rvalid), 64'd0);
        @(negedge clk);

        own(2'd0, 1, 2'd0); own(2'd1, 1, 2'd1); own(2'd2, 1, 2'd2);

        // R2, R3: table of single-port accesses
        foreach (VECS[i]) begin
            idle();
            acc(int'(VECS[i].port), VECS[i].we, VECS[i].bank, VECS[i].addr, VECS[i].wd);
            tick();
            chk($sformatf("R2/R3 vec%0d rvalid", i), 64'(acc_rvalid[VECS[i].port]), 64'(VECS[i].ev));
            if (VECS[i].ev) chk($sformatf("R2 vec%0d rdata", i), acc_rdata[VECS[i].port], VECS[i].ed);
            idle();
        end
        chk("R3 sticky err p0,p1", 64'(acc_err), 64'h3);

        // R5: owner writes half0 while bus writes half1 of bank0
        idle(); acc(0, 1, 2'd0, 4'd4, D_F); bus(1, 1'b1, 2'd0, 4'd3, D_E);
        #1 chk("R5 bus_ready other half", 64'(bus_ready), 64'd1);
        tick(); idle();
        // R4: bus reads back both halves
        bus(0, 1'b1, 2'd0, 4'd3, 0); tick();
        chk("R4 bus_rvalid", 64'(bus_rvalid), 64'd1);
        chk("R4/R5 bus half1 data", bus_rdata, D_E);
        idle(); bus(0, 1'b0, 2'd0, 4'd4, 0); tick();
        chk("R5 owner write landed in half0", bus_rdata, D_F);
        idle();

        // R6: clash on accelerator-side half, bus write dropped
        acc(0, 0, 2'd0, 4'd3, 0); bus(1, 1'b0, 2'd0, 4'd3, D_Z);
        #1 chk("R6 bus_ready low on clash", 64'(bus_ready), 64'd0);
        tick();
        chk("R6 owner read served", acc_rdata[0], D_A);
        idle(); acc(0, 0, 2'd0, 4'd3, 0); tick();
        chk("R6 stalled write not stored", acc_rdata[0], D_A);
        idle(); acc(0, 0, 2'd0, 4'd7, 0); bus(0, 1'b0, 2'd0, 4'd7, 0);
        #1 chk("R6 bus_ready low on read clash", 64'(bus_ready), 64'd0);
        tick();
        chk("R6 stalled read no bus_rvalid", 64'(bus_rvalid), 64'd0);
        idle();

        // R8: swap refused while bank busy
        acc(0, 0, 2'd0, 4'd3, 0); swap_req = 1; swap_bank = 2'd0;
        #1 chk("R8 swap refused owner busy", 64'(swap_ack), 64'd0);
        tick(); idle();
        bus(0, 1'b1, 2'd0, 4'd3, 0); swap_req = 1; swap_bank = 2'd0;
        #1 chk("R8 swap refused bus busy", 64'(swap_ack), 64'd0);
        tick(); idle();
        acc(0, 0, 2'd0, 4'd3, 0); tick();
        chk("R8 roles unchanged", acc_rdata[0], D_A);
        idle();

        // R7: swap on quiet bank
        swap_req = 1; swap_bank = 2'd0;
        #1 chk("R7 swap_ack", 64'(swap_ack), 64'd1);
        tick(); idle();
        acc(0, 0, 2'd0, 4'd3, 0); tick();
        chk("R7 owner sees bus-filled half", acc_rdata[0], D_E);
        idle(); bus(0, 1'b0, 2'd0, 4'd3, 0); tick();
        chk("R7 bus sees former owner half", bus_rdata, D_A);
        idle();

        // R9: three ports on three banks at once
        acc(0, 0, 2'd0, 4'd3, 0); acc(1, 0, 2'd1, 4'd0, 0); acc(2, 1, 2'd2, 4'd1, D_B);
        tick();
        chk("R9 rvalid pattern", 64'(acc_rvalid), 64'h3);
        chk("R9 p0 data", acc_rdata[0], D_E);
        chk("R9 p1 data", acc_rdata[1], D_C);
        idle(); acc(2, 0, 2'd2, 4'd1, 0); tick();
        chk("R9 p2 write stored", acc_rdata[2], D_B);
        idle();

        // R10: move bank1 to p2
        own(2'd1, 1, 2'd2);
        acc(1, 0, 2'd1, 4'd0, 0); tick();
        chk("R10 old owner ignored", 64'(acc_rvalid[1]), 64'd0);
        idle(); acc(2, 0, 2'd1, 4'd0, 0); tick();
        chk("R10 new owner rvalid", 64'(acc_rvalid[2]), 64'd1);
        chk("R10 new owner data", acc_rdata[2], D_C);
        idle();

        // R1: reset clears ownership and errors
        do_reset();
        #1 chk("R1 err cleared", 64'(acc_err), 64'd0);
        @(negedge clk);
        acc(0, 0, 2'd0, 4'd3, 0); tick();
        chk("R1 no owner after reset", 64'(acc_rvalid[0]), 64'd0);
        chk("R1 err on unowned", 64'(acc_err), 64'h1);
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule